// File: doc/BRIEF.md
# Physical-to-Virtual Interrupt Forwarder

This block turns physical interrupt arrivals into virtual interrupts for a set of guests that share one machine. A small table, written only during boot, ties every physical line to one guest and one virtual interrupt number inside that guest. The table never lets two lines share the same guest and number. Once boot is finished, the table is frozen.

Each physical line has its own state machine with four states: `LS_IDLE` (inactive), `LS_PEND` (arrived, waiting for acknowledge), `LS_HELD` (acknowledged and active, virtual interrupt not yet delivered) and `LS_LIVE` (active, virtual interrupt delivered and outstanding). The transitions are:
- arrival: `LS_IDLE`→`LS_PEND`
- acknowledge grant: `LS_PEND`→`LS_HELD`
- inject grant, given only while the owning guest's running bit is set: `LS_HELD`→`LS_LIVE`
- matching virtual end-of-interrupt: `LS_LIVE`→`LS_IDLE`, or `LS_LIVE`→`LS_PEND` when a repeat arrival was recorded while the line was active.

The table has two states, `CFG_OPEN` and `CFG_LOCKED`. The transition `CFG_OPEN`→`CFG_LOCKED` is taken when boot-done is first seen high, and it is never left.

A guest that is asleep keeps its interrupts in `LS_HELD`. When its running bit is set, the held lines are delivered one per cycle, lowest line number first. The guest's virtual end-of-interrupt retires the physical line as well.

Top module: `pirq_forwarder`

## Requirements
- R1: After reset all lines are inactive and not pending, every output pulse is low, and line i maps to guest (i mod 4) with virtual number (i div 4).
- R2: While the table is in `CFG_OPEN` and boot_done is low, a write with cfg_we replaces the entry of line cfg_line. Once boot_done has been seen high, every write is ignored and no reject is raised.
- R3: An open-phase write whose guest and virtual number equal those of any other line is rejected. The table is left unchanged, and cfg_reject pulses in the cycle after the write.
- R4: An arrival on an inactive line raises pirq_pending for that line one cycle later. Lines are acknowledged one per cycle, lowest pending line first. The acknowledge is shown as ack_valid with ack_line, and the line becomes active in that same cycle.
- R5: A held line whose owning guest has its guest_running bit set is injected. inj_valid pulses with inj_line, and with inj_guest and inj_virq taken from the table.
- R6: While the owning guest's running bit is low, a line stays active and nothing is injected for it.
- R7: When several lines are eligible for injection, they are injected one per cycle in ascending line number.
- R8: A virtual end-of-interrupt whose guest and number match a line in the injected state makes that physical line inactive in the next cycle.
- R9: A virtual end-of-interrupt that matches no injected line changes no line state, and veoi_bad pulses in the next cycle.
- R10: An arrival on an active line is held in pirq_pending and is not acknowledged. When that line is retired, it goes straight back to pending and is then acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_line | input | 3 | Physical line being written |
| cfg_guest | input | 2 | Guest for that line |
| cfg_virq | input | 3 | Virtual number for that line |
| boot_done | input | 1 | Boot finished; locks the table permanently |
| cfg_reject | output | 1 | Pulse: last write refused as a duplicate pair |
| pirq_arrive | input | 8 | One-cycle arrival pulse per physical line |
| pirq_pending | output | 8 | Line has an arrival not yet acknowledged |
| pirq_active | output | 8 | Line acknowledged and not yet retired |
| ack_valid | output | 1 | Pulse: one line acknowledged |
| ack_line | output | 3 | Line acknowledged |
| guest_running | input | 4 | Per-guest running bitmap from the scheduler |
| inj_valid | output | 1 | Pulse: virtual interrupt injected |
| inj_line | output | 3 | Physical line behind the injection |
| inj_guest | output | 2 | Target guest |
| inj_virq | output | 3 | Virtual interrupt number |
| veoi_valid | input | 1 | Virtual end-of-interrupt strobe |
| veoi_guest | input | 2 | Guest issuing it |
| veoi_virq | input | 3 | Virtual number being ended |
| veoi_bad | output | 1 | Pulse: end-of-interrupt matched nothing |

## Verification
The assertions assume that pirq_arrive, veoi and configuration inputs are already synchronous to clk and are held for exactly one cycle per event. They also assume that guest_running is sampled as-is, with no glitch filtering expected of the block. The stimulus drives every input once per cycle on the falling edge. In the random phase, arrivals are single-line pulses, and end-of-interrupts are taken either from lines the bench model holds as injected or from random pairs to provoke the unmatched case. Configuration writes after lock are also included, to check that they are ignored.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    // Per-line interrupt lifecycle
    typedef enum logic [1:0] {
        LS_IDLE = 2'd0,
        LS_PEND = 2'd1,
        LS_HELD = 2'd2,
        LS_LIVE = 2'd3
    } line_state_e;

    // Mapping table phase
    typedef enum logic {
        CFG_OPEN   = 1'b0,
        CFG_LOCKED = 1'b1
    } cfg_state_e;

endpackage

// File: rtl/fwd_pick_low.sv
module fwd_pick_low #(
    parameter int N  = 8,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Lowest set request wins
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/fwd_map_table.sv
module fwd_map_table
    import fwd_pkg::*;
#(
    parameter int NP = 8,
    parameter int NG = 4,
    parameter int NV = 8,
    parameter int PW = $clog2(NP),
    parameter int GW = $clog2(NG),
    parameter int VW = $clog2(NV)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [PW-1:0]          wr_line,
    input  logic [GW-1:0]          wr_guest,
    input  logic [VW-1:0]          wr_virq,
    input  logic                   boot_done,
    output logic                   locked,
    output logic                   wr_reject,
    output logic [NP-1:0][GW-1:0]  guest_tab,
    output logic [NP-1:0][VW-1:0]  virq_tab
);
    cfg_state_e st_q, st_d;
    logic       dup;
    logic       open_wr;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CFG_OPEN;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CFG_OPEN:   if (boot_done) st_d = CFG_LOCKED;
            CFG_LOCKED: st_d = CFG_LOCKED;
            default:    st_d = CFG_LOCKED;
        endcase
    end

    // duplicate-pair detection against every other line
    always_comb begin
        dup = 1'b0;
        for (int j = 0; j < NP; j++) begin
            if (PW'(j) != wr_line && guest_tab[j] == wr_guest && virq_tab[j] == wr_virq)
                dup = 1'b1;
        end
    end

    assign open_wr = wr_en && (st_q == CFG_OPEN) && !boot_done;
    assign locked  = (st_q == CFG_LOCKED);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NP; i++) begin
                guest_tab[i] <= GW'(i % NG);
                virq_tab[i]  <= VW'((i / NG) % NV);
            end
            wr_reject <= 1'b0;
        end else begin
            wr_reject <= open_wr && dup;
            if (open_wr && !dup) begin
                guest_tab[wr_line] <= wr_guest;
                virq_tab[wr_line]  <= wr_virq;
            end
        end
    end
endmodule

// File: rtl/fwd_line_fsm.sv
module fwd_line_fsm
    import fwd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arrive,
    input  logic ack_gnt,
    input  logic inj_gnt,
    input  logic eoi_hit,
    output logic is_pend,
    output logic is_held,
    output logic is_live,
    output logic line_active,
    output logic line_pending
);
    line_state_e st_q, st_d;
    logic        again_q, again_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= LS_IDLE;
            again_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            again_q <= again_d;
        end
    end

    // transitions
    always_comb begin
        st_d    = st_q;
        again_d = again_q;
        unique case (st_q)
            LS_IDLE: begin
                if (arrive) st_d = LS_PEND;
            end
            LS_PEND: begin
                if (ack_gnt) st_d = LS_HELD;
            end
            LS_HELD: begin
                if (inj_gnt) st_d = LS_LIVE;
                if (arrive)  again_d = 1'b1;
            end
            LS_LIVE: begin
                if (eoi_hit) begin
                    st_d    = (again_q || arrive) ? LS_PEND : LS_IDLE;
                    again_d = 1'b0;
                end else if (arrive) begin
                    again_d = 1'b1;
                end
            end
            default: st_d = LS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        is_pend      = (st_q == LS_PEND);
        is_held      = (st_q == LS_HELD);
        is_live      = (st_q == LS_LIVE);
        line_active  = is_held || is_live;
        line_pending = is_pend || again_q;
    end
endmodule

// File: rtl/pirq_forwarder.sv
module pirq_forwarder
    import fwd_pkg::*;
#(
    parameter int NUM_PIRQ  = 8,
    parameter int NUM_GUEST = 4,
    parameter int NUM_VIRQ  = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [$clog2(NUM_PIRQ)-1:0]   cfg_line,
    input  logic [$clog2(NUM_GUEST)-1:0]  cfg_guest,
    input  logic [$clog2(NUM_VIRQ)-1:0]   cfg_virq,
    input  logic                          boot_done,
    output logic                          cfg_reject,
    input  logic [NUM_PIRQ-1:0]           pirq_arrive,
    output logic [NUM_PIRQ-1:0]           pirq_pending,
    output logic [NUM_PIRQ-1:0]           pirq_active,
    output logic                          ack_valid,
    output logic [$clog2(NUM_PIRQ)-1:0]   ack_line,
    input  logic [NUM_GUEST-1:0]          guest_running,
    output logic                          inj_valid,
    output logic [$clog2(NUM_PIRQ)-1:0]   inj_line,
    output logic [$clog2(NUM_GUEST)-1:0]  inj_guest,
    output logic [$clog2(NUM_VIRQ)-1:0]   inj_virq,
    input  logic                          veoi_valid,
    input  logic [$clog2(NUM_GUEST)-1:0]  veoi_guest,
    input  logic [$clog2(NUM_VIRQ)-1:0]   veoi_virq,
    output logic                          veoi_bad
);
    localparam int PW = $clog2(NUM_PIRQ);
    localparam int GW = $clog2(NUM_GUEST);
    localparam int VW = $clog2(NUM_VIRQ);

    logic                        tab_locked;
    logic [NUM_PIRQ-1:0][GW-1:0] tab_guest;
    logic [NUM_PIRQ-1:0][VW-1:0] tab_virq;

    logic [NUM_PIRQ-1:0] is_pend, is_held, is_live;
    logic [NUM_PIRQ-1:0] ack_gnt, inj_gnt, eoi_hit, inj_ready;
    logic                ack_found, inj_found;
    logic [PW-1:0]       ack_pick, inj_pick;

    fwd_map_table #(
        .NP(NUM_PIRQ), .NG(NUM_GUEST), .NV(NUM_VIRQ)
    ) u_tab (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we),
        .wr_line   (cfg_line),
        .wr_guest  (cfg_guest),
        .wr_virq   (cfg_virq),
        .boot_done (boot_done),
        .locked    (tab_locked),
        .wr_reject (cfg_reject),
        .guest_tab (tab_guest),
        .virq_tab  (tab_virq)
    );

    // eligibility per line
    always_comb begin
        for (int i = 0; i < NUM_PIRQ; i++) begin
            inj_ready[i] = is_held[i] && guest_running[tab_guest[i]];
            eoi_hit[i]   = veoi_valid && is_live[i]
                           && tab_guest[i] == veoi_guest
                           && tab_virq[i] == veoi_virq;
        end
    end

    fwd_pick_low #(.N(NUM_PIRQ), .IW(PW)) u_ack_pick (
        .req(is_pend), .found(ack_found), .idx(ack_pick)
    );

    fwd_pick_low #(.N(NUM_PIRQ), .IW(PW)) u_inj_pick (
        .req(inj_ready), .found(inj_found), .idx(inj_pick)
    );

    always_comb begin
        for (int i = 0; i < NUM_PIRQ; i++) begin
            ack_gnt[i] = ack_found && (ack_pick == PW'(i));
            inj_gnt[i] = inj_found && (inj_pick == PW'(i));
        end
    end

    for (genvar g = 0; g < NUM_PIRQ; g++) begin : g_line
        fwd_line_fsm u_line (
            .clk          (clk),
            .rst_n        (rst_n),
            .arrive       (pirq_arrive[g]),
            .ack_gnt      (ack_gnt[g]),
            .inj_gnt      (inj_gnt[g]),
            .eoi_hit      (eoi_hit[g]),
            .is_pend      (is_pend[g]),
            .is_held      (is_held[g]),
            .is_live      (is_live[g]),
            .line_active  (pirq_active[g]),
            .line_pending (pirq_pending[g])
        );
    end

    // registered event outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_valid <= 1'b0;
            ack_line  <= '0;
            inj_valid <= 1'b0;
            inj_line  <= '0;
            inj_guest <= '0;
            inj_virq  <= '0;
            veoi_bad  <= 1'b0;
        end else begin
            ack_valid <= ack_found;
            ack_line  <= ack_pick;
            inj_valid <= inj_found;
            inj_line  <= inj_pick;
            inj_guest <= tab_guest[inj_pick];
            inj_virq  <= tab_virq[inj_pick];
            veoi_bad  <= veoi_valid && (eoi_hit == '0);
        end
    end
endmodule

// File: rtl/fwd_checker.sv
module fwd_checker #(
    parameter int NP = 8,
    parameter int NG = 4,
    parameter int NV = 8,
    parameter int PW = $clog2(NP),
    parameter int GW = $clog2(NG),
    parameter int VW = $clog2(NV)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  locked,
    input logic [NP-1:0][GW-1:0] tab_guest,
    input logic [NP-1:0][VW-1:0] tab_virq,
    input logic [NP-1:0]         pirq_active,
    input logic                  ack_valid,
    input logic [PW-1:0]         ack_line,
    input logic [NG-1:0]         guest_running,
    input logic                  inj_valid,
    input logic [GW-1:0]         inj_guest,
    input logic                  veoi_valid,
    input logic                  veoi_bad
);
    assert_table_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(locked) |-> ($stable(tab_guest) && $stable(tab_virq)));

    assert_ack_activates_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> ((pirq_active & (NP'(1) << ack_line)) != '0));

    assert_inject_running_R5: assert property (@(posedge clk) disable iff (!rst_n)
        inj_valid |-> (($past(guest_running) & (NG'(1) << inj_guest)) != '0));

    assert_retire_by_eoi_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(pirq_active) & ~pirq_active) != '0) |-> $past(veoi_valid));

    assert_bad_eoi_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        veoi_bad |-> $past(veoi_valid));

    assert_no_ack_while_active_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> (($past(pirq_active) & (NP'(1) << ack_line)) == '0));
endmodule

bind pirq_forwarder fwd_checker #(
    .NP(NUM_PIRQ), .NG(NUM_GUEST), .NV(NUM_VIRQ)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .locked        (tab_locked),
    .tab_guest     (tab_guest),
    .tab_virq      (tab_virq),
    .pirq_active   (pirq_active),
    .ack_valid     (ack_valid),
    .ack_line      (ack_line),
    .guest_running (guest_running),
    .inj_valid     (inj_valid),
    .inj_guest     (inj_guest),
    .veoi_valid    (veoi_valid),
    .veoi_bad      (veoi_bad)
);

// File: tb/pirq_forwarder_test.sv
module pirq_forwarder_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_line = '0;
    logic [1:0] cfg_guest = '0;
    logic [2:0] cfg_virq = '0;
    logic       boot_done = 1'b0;
    logic       cfg_reject;
    logic [7:0] pirq_arrive = '0;
    logic [7:0] pirq_pending, pirq_active;
    logic       ack_valid;
    logic [2:0] ack_line;
    logic [3:0] guest_running = 4'b1111;
    logic       inj_valid;
    logic [2:0] inj_line;
    logic [1:0] inj_guest;
    logic [2:0] inj_virq;
    logic       veoi_valid = 1'b0;
    logic [1:0] veoi_guest = '0;
    logic [2:0] veoi_virq = '0;
    logic       veoi_bad;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    bit cmp_en = 0;

    always #10 clk = ~clk;

    pirq_forwarder uut (.*);

    // ---------------- reference model ----------------
    int  m_st[8];
    bit  m_rpt[8];
    int  m_g[8];
    int  m_v[8];
    bit  m_lock;
    bit  e_ack, e_inj, e_bad, e_rej;
    int  e_ackl, e_injl, e_injg, e_injv;

    function automatic void model_reset();
        for (int i = 0; i < 8; i++) begin
            m_st[i] = 0; m_rpt[i] = 0; m_g[i] = i % 4; m_v[i] = i / 4;
        end
        m_lock = 0; e_ack = 0; e_inj = 0; e_bad = 0; e_rej = 0;
        e_ackl = 0; e_injl = 0; e_injg = 0; e_injv = 0;
    endfunction

    initial model_reset();

    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else begin
            int  ai, ji, ei;
            bit  dup, wok;
            ai = -1; ji = -1; ei = -1;
            for (int i = 7; i >= 0; i--) begin
                if (m_st[i] == 1) ai = i;
                if (m_st[i] == 2 && guest_running[m_g[i]]) ji = i;
                if (veoi_valid && m_st[i] == 3 && m_g[i] == int'(veoi_guest)
                    && m_v[i] == int'(veoi_virq)) ei = i;
            end
            e_ack = (ai >= 0); if (ai >= 0) e_ackl = ai;
            e_inj = (ji >= 0);
            if (ji >= 0) begin e_injl = ji; e_injg = m_g[ji]; e_injv = m_v[ji]; end
            e_bad = veoi_valid && (ei < 0);
            dup = 0;
            for (int i = 0; i < 8; i++)
                if (i != int'(cfg_line) && m_g[i] == int'(cfg_guest) && m_v[i] == int'(cfg_virq)) dup = 1;
            wok = cfg_we && !m_lock && !boot_done;
            e_rej = wok && dup;
            for (int i = 0; i < 8; i++) begin
                bit a;
                a = pirq_arrive[i];
                case (m_st[i])
                    0: if (a) m_st[i] = 1;
                    1: if (i == ai) m_st[i] = 2;
                    2: begin if (i == ji) m_st[i] = 3; if (a) m_rpt[i] = 1; end
                    default: begin
                        if (i == ei) begin m_st[i] = (m_rpt[i] || a) ? 1 : 0; m_rpt[i] = 0; end
                        else if (a) m_rpt[i] = 1;
                    end
                endcase
            end
            if (wok && !dup) begin m_g[cfg_line] = cfg_guest; m_v[cfg_line] = cfg_virq; end
            if (boot_done) m_lock = 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_en) begin
            logic [7:0] ea, ep;
            for (int i = 0; i < 8; i++) begin
                ea[i] = (m_st[i] >= 2);
                ep[i] = (m_st[i] == 1) || m_rpt[i];
            end
            chk(pirq_active == ea, "R8", "model active", int'(pirq_active), int'(ea));
            chk(pirq_pending == ep, "R4", "model pending", int'(pirq_pending), int'(ep));
            chk(ack_valid == e_ack && (!e_ack || int'(ack_line) == e_ackl), "R4", "model ack line",
                ack_valid ? int'(ack_line) : -1, e_ack ? e_ackl : -1);
            chk(inj_valid == e_inj && (!e_inj || (int'(inj_line) == e_injl && int'(inj_guest) == e_injg
                && int'(inj_virq) == e_injv)), "R5", "model inject line",
                inj_valid ? int'(inj_line) : -1, e_inj ? e_injl : -1);
            chk(veoi_bad == e_bad, "R9", "model veoi_bad", int'(veoi_bad), int'(e_bad));
            chk(cfg_reject == e_rej, "R3", "model cfg_reject", int'(cfg_reject), int'(e_rej));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic arrive(input int ln);
        @(negedge clk); pirq_arrive = 8'(1 << ln);
        @(negedge clk); pirq_arrive = '0;
    endtask

    task automatic eoi(input int g, input int v);
        @(negedge clk); veoi_valid = 1; veoi_guest = 2'(g); veoi_virq = 3'(v);
        @(negedge clk); veoi_valid = 0;
    endtask

    task automatic cfg_wr(input int ln, input int g, input int v);
        @(negedge clk); cfg_we = 1; cfg_line = 3'(ln); cfg_guest = 2'(g); cfg_virq = 3'(v);
        @(negedge clk); cfg_we = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1c0de5));
        repeat (3) @(negedge clk);
        rst_n = 1;
        cmp_en = 1;
        @(negedge clk);
        // R1 reset state
        chk(pirq_active == 0 && pirq_pending == 0, "R1", "reset line state", int'(pirq_active), 0);
        chk(!ack_valid && !inj_valid && !veoi_bad && !cfg_reject, "R1", "reset pulses",
            int'({ack_valid, inj_valid, veoi_bad, cfg_reject}), 0);

        // R1 default map, R4 ack path, R5 injection, R8 retire
        arrive(5);
        chk(pirq_pending[5] == 1, "R4", "pending after arrival", int'(pirq_pending), 8'h20);
        @(negedge clk);
        chk(ack_valid && ack_line == 5 && pirq_active[5], "R4", "ack line 5", int'(ack_line), 5);
        @(negedge clk);
        chk(inj_valid && inj_guest == 1 && inj_virq == 1, "R1", "default pair of line 5",
            int'({inj_guest, inj_virq}), (1 << 3) | 1);
        eoi(1, 1);
        chk(pirq_active[5] == 0 && !veoi_bad, "R8", "line 5 retired", int'(pirq_active), 0);

        // R2 open write, R3 duplicate reject
        cfg_wr(0, 3, 7);
        chk(cfg_reject == 0, "R2", "unique write accepted", int'(cfg_reject), 0);
        cfg_wr(1, 3, 7);
        chk(cfg_reject == 1, "R3", "duplicate write rejected", int'(cfg_reject), 1);
        arrive(0); @(negedge clk); @(negedge clk);
        chk(inj_valid && inj_guest == 3 && inj_virq == 7, "R2", "line 0 remapped",
            int'({inj_guest, inj_virq}), (3 << 3) | 7);
        eoi(3, 7);
        arrive(1); @(negedge clk); @(negedge clk);
        chk(inj_valid && inj_guest == 1 && inj_virq == 0, "R3", "line 1 unchanged",
            int'({inj_guest, inj_virq}), (1 << 3) | 0);
        eoi(1, 0);

        // R2 lock
        @(negedge clk); boot_done = 1;
        cfg_wr(0, 2, 6);
        chk(cfg_reject == 0, "R2", "locked write not flagged", int'(cfg_reject), 0);
        arrive(0); @(negedge clk); @(negedge clk);
        chk(inj_valid && inj_guest == 3 && inj_virq == 7, "R2", "locked table kept",
            int'({inj_guest, inj_virq}), (3 << 3) | 7);
        eoi(3, 7);

        // R6 deferral, R7 ascending release
        @(negedge clk); guest_running = 4'b1011;
        arrive(6);
        arrive(2);
        repeat (4) begin
            @(negedge clk);
            chk(!inj_valid, "R6", "no inject while asleep", int'(inj_valid), 0);
        end
        chk(pirq_active[2] && pirq_active[6], "R6", "held lines active", int'(pirq_active), 8'h44);
        guest_running = 4'b1111;
        @(negedge clk);
        chk(inj_valid && inj_line == 2, "R7", "first release line 2", int'(inj_line), 2);
        @(negedge clk);
        chk(inj_valid && inj_line == 6, "R7", "second release line 6", int'(inj_line), 6);

        // R8 retire, R9 unmatched eoi
        eoi(2, 0);
        chk(pirq_active[2] == 0, "R8", "line 2 retired", int'(pirq_active[2]), 0);
        eoi(2, 0);
        chk(veoi_bad == 1, "R9", "repeat eoi flagged", int'(veoi_bad), 1);
        chk(pirq_active[6] == 1, "R9", "unmatched eoi leaves line 6", int'(pirq_active[6]), 1);

        // R10 arrival on an active line
        arrive(6);
        chk(pirq_pending[6] && pirq_active[6], "R10", "repeat held pending",
            int'({pirq_pending[6], pirq_active[6]}), 3);
        repeat (3) begin
            @(negedge clk);
            chk(!ack_valid, "R10", "no ack while active", int'(ack_valid), 0);
        end
        eoi(2, 1);
        chk(!pirq_active[6] && pirq_pending[6], "R10", "retire returns to pending",
            int'({pirq_pending[6], pirq_active[6]}), 2);
        @(negedge clk);
        chk(ack_valid && ack_line == 6, "R10", "re-ack line 6", int'(ack_line), 6);
        @(negedge clk);
        eoi(2, 1);

        // constrained random phase
        for (int c = 0; c < 3000; c++) begin
            int r;
            @(negedge clk);
            pirq_arrive = ($urandom % 6 == 0) ? 8'(1 << ($urandom % 8)) : 8'h00;
            if ($urandom % 16 == 0) guest_running[$urandom % 4] = ~guest_running[$urandom % 4];
            cfg_we = ($urandom % 32 == 0);
            cfg_line = 3'($urandom); cfg_guest = 2'($urandom); cfg_virq = 3'($urandom);
            r = $urandom % 4;
            veoi_valid = 0;
            if (r == 0) begin
                veoi_valid = 1; veoi_guest = 2'($urandom); veoi_virq = 3'($urandom);
            end else if (r == 1) begin
                int off;
                off = $urandom % 8;
                for (int k = 0; k < 8; k++) begin
                    int ln;
                    ln = (off + k) % 8;
                    if (!veoi_valid && m_st[ln] == 3) begin
                        veoi_valid = 1; veoi_guest = 2'(m_g[ln]); veoi_virq = 3'(m_v[ln]);
                    end
                end
            end
        end
        @(negedge clk);
        pirq_arrive = '0; veoi_valid = 0; cfg_we = 0;
        repeat (4) @(negedge clk);
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule